// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

The arbiter watches a set of devices, each with a ready flag, an interrupt-enable flag and a fixed 3-bit urgency level (0 lowest, 7 highest). A device takes part in arbitration only while both of its flags are set. Among the devices taking part, a priority encoder finds the most urgent one; when two share the top level, the one with the smaller index is chosen.

The chosen level is compared with the level the processor is running at. The processor raises a strobe at the point between the end of one instruction's store phase and the next fetch; on that edge the arbiter decides. If the winner is strictly more urgent than the processor, a one-cycle interrupt-taken pulse is issued along with the winner's index and level. Otherwise nothing happens and the program carries on with the next instruction. Saving state and jumping to a handler belong to other blocks.

Top module: `pri_irq_arbiter`

## Requirements
- R1: While rst_n is low and after its release, irq_take, irq_dev and irq_level are all 0 until the first interrupt is taken.
- R2: A device requests only when its dev_ready bit and its dev_ien bit are both 1; a device with only one of them set never causes irq_take.
- R3: Among requesting devices the one with the highest level (level of device i is dev_level[3*i+2:3*i]) is reported on irq_dev and irq_level.
- R4: When several requesting devices share the highest level, the lowest device index wins.
- R5: irq_take is raised only when the winning level is strictly greater than cpu_level; an equal or lower winning level gives no interrupt.
- R6: The decision is made only on a rising clock edge where boundary_stb is 1; without the strobe irq_take stays 0 whatever the requests.
- R7: irq_take is a registered pulse, high for exactly the one cycle following the edge that sampled a single-cycle strobe.
- R8: irq_dev and irq_level are loaded only when an interrupt is taken and otherwise hold their previous values.
- R9: A program at level 7 is never interrupted; a level-7 device does interrupt a program at level 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_ready | input | 8 | Per-device ready flag |
| dev_ien | input | 8 | Per-device interrupt-enable flag |
| dev_level | input | 24 | Per-device 3-bit level, device i at bits 3*i+2:3*i |
| cpu_level | input | 3 | Level of the running program |
| boundary_stb | input | 1 | Strobe between store phase and next fetch |
| irq_take | output | 1 | Interrupt-taken pulse |
| irq_dev | output | 3 | Index of the winning device |
| irq_level | output | 3 | Level of the winning device |

## Verification
All three outputs come from one register stage, so a decision sampled on the strobe edge is visible from that edge until the next one, one cycle of latency. The bench drives inputs and the strobe on the falling edge, lets one rising edge pass, and reads irq_take, irq_dev and irq_level at the following falling edge; one cycle later it reads irq_take again to confirm the pulse has ended. Cases without a strobe are read over several falling edges to show nothing moves.

// File: rtl/pri_arb_pkg.sv
package pri_arb_pkg;
  localparam int unsigned PA_LVL_W = 3;
  typedef logic [PA_LVL_W-1:0] pa_level_t;
endpackage

// File: rtl/pa_req_qualify.sv
module pa_req_qualify #(
  parameter int unsigned NUM_DEV = 8
) (
  input  logic [NUM_DEV-1:0] ready,
  input  logic [NUM_DEV-1:0] ien,
  output logic [NUM_DEV-1:0] req
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign req[g] = ready[g] & ien[g];
  end
endmodule

// File: rtl/pa_pick_encoder.sv
module pa_pick_encoder
  import pri_arb_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV-1:0]          req,
  input  logic [NUM_DEV*PA_LVL_W-1:0] levels,
  output logic                        any_req,
  output logic [IDX_W-1:0]            win_idx,
  output pa_level_t                   win_lvl
);
  always_comb begin
    any_req = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && (!any_req || (levels[i*PA_LVL_W +: PA_LVL_W] > win_lvl))) begin
        any_req = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = levels[i*PA_LVL_W +: PA_LVL_W];
      end
    end
  end

  // winner must be an actual requester (R3)
  always_comb begin
    if (any_req) begin
      assert_winner_requests_R3: assert (req[win_idx]);
    end
  end
endmodule

// File: rtl/pa_grant_reg.sv
module pa_grant_reg
  import pri_arb_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             any_req,
  input  logic [IDX_W-1:0] win_idx,
  input  pa_level_t        win_lvl,
  input  pa_level_t        cpu_lvl,
  output logic             take,
  output logic [IDX_W-1:0] dev_q,
  output pa_level_t        lvl_q
);
  logic             take_d;
  logic             load_en;

  always_comb begin
    take_d  = stb & any_req & (win_lvl > cpu_lvl);
    load_en = take_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take <= 1'b0;
    end else begin
      take <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      lvl_q <= '0;
    end else if (load_en) begin
      dev_q <= win_idx;
      lvl_q <= win_lvl;
    end
  end

  assert_take_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(stb));
  assert_above_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (lvl_q > $past(cpu_lvl)));
  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> ($stable(dev_q) && $stable(lvl_q)));
  assert_top_never_interrupted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_lvl) == 3'd7) |-> !take);
endmodule

// File: rtl/pri_irq_arbiter.sv
module pri_irq_arbiter
  import pri_arb_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DEV-1:0]          dev_ready,
  input  logic [NUM_DEV-1:0]          dev_ien,
  input  logic [NUM_DEV*PA_LVL_W-1:0] dev_level,
  input  logic [PA_LVL_W-1:0]         cpu_level,
  input  logic                        boundary_stb,
  output logic                        irq_take,
  output logic [IDX_W-1:0]            irq_dev,
  output logic [PA_LVL_W-1:0]         irq_level
);
  logic [NUM_DEV-1:0] req;
  logic               any_req;
  logic [IDX_W-1:0]   win_idx;
  pa_level_t          win_lvl;

  pa_req_qualify #(.NUM_DEV(NUM_DEV)) u_qual (
    .ready (dev_ready),
    .ien   (dev_ien),
    .req   (req)
  );

  pa_pick_encoder #(.NUM_DEV(NUM_DEV)) u_enc (
    .req     (req),
    .levels  (dev_level),
    .any_req (any_req),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  pa_grant_reg #(.IDX_W(IDX_W)) u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (boundary_stb),
    .any_req (any_req),
    .win_idx (win_idx),
    .win_lvl (win_lvl),
    .cpu_lvl (cpu_level),
    .take    (irq_take),
    .dev_q   (irq_dev),
    .lvl_q   (irq_level)
  );
endmodule

// File: tb/test_pri_irq_arbiter.sv
module test_pri_irq_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  dev_ready, dev_ien;
  logic [23:0] dev_level;
  logic [2:0]  cpu_level;
  logic        boundary_stb;
  logic        irq_take;
  logic [2:0]  irq_dev, irq_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pri_irq_arbiter i_pri_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .dev_ien(dev_ien),
    .dev_level(dev_level), .cpu_level(cpu_level), .boundary_stb(boundary_stb),
    .irq_take(irq_take), .irq_dev(irq_dev), .irq_level(irq_level)
  );

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_devs();
    dev_ready = '0; dev_ien = '0; dev_level = '0;
  endtask

  task automatic set_dev(input int idx, input int lvl, input bit rdy, input bit en);
    dev_ready[idx] = rdy;
    dev_ien[idx]   = en;
    dev_level[idx*3 +: 3] = 3'(lvl);
  endtask

  // strobe for one cycle at current negedge; check results one cycle later
  task automatic strobe_and_check(input string tag, input bit exp_take,
                                  input int exp_dev, input int exp_lvl);
    boundary_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    boundary_stb = 1'b0;
    check_val({tag, " take"}, int'(irq_take), int'(exp_take));
    check_val({tag, " dev"}, int'(irq_dev), exp_dev);
    check_val({tag, " level"}, int'(irq_level), exp_lvl);
    @(negedge clk);
    check_val({tag, " R7 pulse end"}, int'(irq_take), 0);
  endtask

  task automatic t_reset();
    check_val("R1 take", int'(irq_take), 0);
    check_val("R1 dev", int'(irq_dev), 0);
    check_val("R1 level", int'(irq_level), 0);
  endtask

  task automatic t_enable_gate();
    clear_devs(); cpu_level = 3'd0;
    set_dev(3, 5, 1'b1, 1'b0);
    strobe_and_check("R2 ready only", 1'b0, 0, 0);
    set_dev(3, 5, 1'b0, 1'b1);
    strobe_and_check("R2 enable only", 1'b0, 0, 0);
    set_dev(3, 5, 1'b1, 1'b1);
    strobe_and_check("R2 both", 1'b1, 3, 5);
  endtask

  task automatic t_highest();
    clear_devs(); cpu_level = 3'd1;
    set_dev(1, 2, 1'b1, 1'b1);
    set_dev(4, 6, 1'b1, 1'b1);
    set_dev(6, 3, 1'b1, 1'b1);
    set_dev(7, 7, 1'b1, 1'b0); // not enabled: ignored
    strobe_and_check("R3 highest", 1'b1, 4, 6);
  endtask

  task automatic t_tie();
    clear_devs(); cpu_level = 3'd0;
    set_dev(5, 4, 1'b1, 1'b1);
    set_dev(2, 4, 1'b1, 1'b1);
    set_dev(6, 4, 1'b1, 1'b1);
    strobe_and_check("R4 tie", 1'b1, 2, 4);
    clear_devs();
    set_dev(0, 1, 1'b1, 1'b1);
    set_dev(7, 1, 1'b1, 1'b1);
    strobe_and_check("R4 tie ends", 1'b1, 0, 1);
  endtask

  task automatic t_threshold();
    clear_devs();
    set_dev(6, 3, 1'b1, 1'b1);
    cpu_level = 3'd2;
    strobe_and_check("R5 above", 1'b1, 6, 3);
    set_dev(6, 4, 1'b1, 1'b1);
    cpu_level = 3'd4;
    strobe_and_check("R5 equal", 1'b0, 6, 3);   // outputs held (R8)
    cpu_level = 3'd5;
    strobe_and_check("R5 below", 1'b0, 6, 3);
  endtask

  task automatic t_top_level();
    clear_devs();
    set_dev(1, 7, 1'b1, 1'b1);
    cpu_level = 3'd7;
    strobe_and_check("R9 at seven", 1'b0, 6, 3);
    cpu_level = 3'd6;
    strobe_and_check("R9 at six", 1'b1, 1, 7);
  endtask

  task automatic t_no_strobe();
    clear_devs();
    set_dev(5, 6, 1'b1, 1'b1);
    cpu_level = 3'd0;
    boundary_stb = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_val("R6 no strobe take", int'(irq_take), 0);
      check_val("R8 no strobe dev held", int'(irq_dev), 1);
      check_val("R8 no strobe level held", int'(irq_level), 7);
    end
    strobe_and_check("R6 strobe fires", 1'b1, 5, 6);
  endtask

  initial begin
    rst_n = 1'b0;
    boundary_stb = 1'b0;
    cpu_level = '0;
    clear_devs();
    set_dev(2, 7, 1'b1, 1'b1);
    boundary_stb = 1'b1;   // strobe during reset must be ignored
    repeat (3) @(negedge clk);
    t_reset();
    boundary_stb = 1'b0;
    clear_devs();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_gate();
    t_highest();
    t_tie();
    t_threshold();
    t_top_level();
    t_no_strobe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule